// File: doc/BRIEF.md
# Synchronous Serial Port Host Front End

This block is the host side of a synchronous serial master. A small word-wide register port lets software set the frame length and the bit rate and queue outgoing words. It can also collect incoming words and read a five-flag status word. Words written to the data register go into an eight-entry transmit queue. A frame engine takes them one by one and shifts each out most significant bit first on a four-wire link: serial clock, active-low select, master-out and master-in. Clock polarity and phase are both zero. The bits that come back during the frame are gathered into a word that goes into an eight-entry receive queue. Reads of the data register take words from that queue.

The bit rate comes from the system clock divided twice. The first divisor is an even prescale value. The second is the control register's divider code plus one. A frame starts as soon as a word reaches an empty transmit queue while the engine is idle. When words are already queued, the new word waits its turn behind them.

Top module: `ssp_host_port`

## Requirements
- R1: After reset the status word reads 0x0003, the prescale register reads 0, select is high and the serial clock is low.
- R2: Register offsets: 0 is control (bits 3:0 size code, bits 11:4 divider code), 1 is data, 2 is status (read-only, bits 15:5 read as 0), 3 is prescale.
- R3: A data write into an empty transmit queue while no frame is active pulls select low on the second clock edge after the write.
- R4: Each frame keeps select low throughout. The serial clock idles low. The master-out line changes only on falling edges, bits go out most significant first, and the incoming line is sampled on rising edges.
- R5: Frame length is the size code plus one. Codes 0, 1 and 2 give 4-bit frames.
- R6: One bit takes P×(D+1) system clocks, where P is the prescale value (values below 2 act as 2) and D is the divider code. Prescale bit 0 is always stored and read as 0.
- R7: Received words come back in the low-order bits with all higher bits zero. Reads return the oldest word first.
- R8: Status bits: 0 transmit queue empty, 1 transmit queue not full, 2 receive queue not empty, 3 receive queue full, 4 busy.
- R9: Busy reads 1 while a frame is shifting or the transmit queue holds any word.
- R10: A data write while the transmit queue holds eight words is ignored.
- R11: A data read while the receive queue is empty returns 0 and leaves the queue unchanged.
- R12: A frame that ends while the receive queue is full is dropped, and stored words are not overwritten.
- R13: Queued words are sent in write order, and only the low bits of each word up to the frame length are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the receive queue when at the data offset) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current offset |
| sclk | output | 1 | Serial bit clock |
| ss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench loops master-out back to master-in so that every frame returns its own data. It then goes after the edges of both queues. Ten back-to-back writes at the slowest bit rate must yield exactly nine frames. A design that stored the tenth word would show ten select pulses, and one that overwrote a full receive queue would return the ninth word in place of an earlier one. Reads from an empty queue must give zero and leave the status at its idle value. A design that still moved its pointers would later hand back stale words. Short size codes, odd prescale writes and the measured serial clock period expose a wrong length clamp, a low prescale bit kept in the register, or an off-by-one in the divider chain.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W = 16;
    localparam int LEN_W  = 5;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_STAT = 2'd2,
        REG_PSC  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] div_code;
        logic [3:0] size_code;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_some;
        logic tx_room;
        logic tx_none;
    } stat_t;

    function automatic logic [LEN_W-1:0] frame_len(input logic [3:0] code);
        return (code < 4'd3) ? LEN_W'(4) : LEN_W'(code) + LEN_W'(1);
    endfunction

    function automatic logic [HALF_W-1:0] half_limit(input logic [7:0] psc,
                                                     input logic [7:0] div_code);
        logic [6:0]  half_p;
        logic [8:0]  mult;
        logic [HALF_W-1:0] prod;
        half_p = (psc < 8'd2) ? 7'd1 : psc[7:1];
        mult   = {1'b0, div_code} + 9'd1;
        prod   = HALF_W'(half_p) * HALF_W'(mult);
        return prod - HALF_W'(1);
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_data;
                wptr      <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            end
            if (do_pop)
                rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R10
    AST_FULL_PUSH_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(wptr))); // R12
    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (empty && $stable(rptr))); // R11

endmodule

// File: rtl/ssp_rate_gen.sv
module ssp_rate_gen
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] limit,
    output logic              half_tick
);
    logic [HALF_W-1:0] cnt;

    assign half_tick = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || half_tick)
            cnt <= '0;
        else
            cnt <= cnt + HALF_W'(1);
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R6

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len,
    input  logic              half_tick,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              active,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi
);
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic [LEN_W-1:0]  left;
    logic              sclk_q, act_q, push_q;

    assign tx_pop  = !act_q && tx_valid;
    assign active  = act_q;
    assign sclk    = sclk_q;
    assign ss_n    = !act_q;
    assign mosi    = tx_sh[WORD_W-1];
    assign rx_push = push_q;
    assign rx_word = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
            push_q <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            left   <= '0;
        end else begin
            push_q <= 1'b0;
            if (!act_q) begin
                if (tx_valid) begin
                    act_q  <= 1'b1;
                    sclk_q <= 1'b0;
                    tx_sh  <= tx_word << (LEN_W'(WORD_W) - len);
                    rx_sh  <= '0;
                    left   <= len - LEN_W'(1);
                end
            end else if (half_tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_sh  <= {rx_sh[WORD_W-2:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (left == '0) begin
                        act_q  <= 1'b0;
                        push_q <= 1'b1;
                    end else begin
                        tx_sh <= tx_sh << 1;
                        left  <= left - LEN_W'(1);
                    end
                end
            end
        end
    end

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> !sclk); // R4
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R4
    AST_PUSH_AT_END: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> $fell(act_q)); // R7

endmodule

// File: rtl/ssp_host_port.sv
module ssp_host_port
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sclk,
    output logic        ss_n,
    output logic        mosi,
    input  logic        miso
);
    ctrl_t             ctrl_q;
    logic [7:0]        psc_q;
    stat_t             stat;
    reg_sel_e          sel;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              active, half_tick;

    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            psc_q  <= '0;
        end else if (reg_wr) begin
            if (sel == REG_CTRL)
                ctrl_q <= ctrl_t'(reg_wdata[11:0]);
            if (sel == REG_PSC)
                psc_q <= {reg_wdata[7:1], 1'b0};
        end
    end

    assign tx_push = reg_wr && (sel == REG_DATA);
    assign rx_pop  = reg_rd && (sel == REG_DATA);

    ssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk(clk), .rst(rst),
        .push(tx_push), .push_data(reg_wdata),
        .pop(tx_pop), .head(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    ssp_rate_gen u_rate (
        .clk(clk), .rst(rst), .run(active),
        .limit(half_limit(psc_q, ctrl_q.div_code)),
        .half_tick(half_tick)
    );

    ssp_shifter u_eng (
        .clk(clk), .rst(rst),
        .tx_valid(!tx_empty), .tx_word(tx_head),
        .len(frame_len(ctrl_q.size_code)),
        .half_tick(half_tick), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .active(active), .sclk(sclk), .ss_n(ss_n), .mosi(mosi)
    );

    always_comb begin
        stat.tx_none = tx_empty;
        stat.tx_room = !tx_full;
        stat.rx_some = !rx_empty;
        stat.rx_full = rx_full;
        stat.busy    = active || !tx_empty;
    end

    always_comb begin
        unique case (sel)
            REG_CTRL: reg_rdata = {4'b0, ctrl_q};
            REG_DATA: reg_rdata = rx_empty ? '0 : rx_head;
            REG_STAT: reg_rdata = {11'b0, stat};
            REG_PSC:  reg_rdata = {8'b0, psc_q};
            default:  reg_rdata = '0;
        endcase
    end

    AST_PSC_EVEN: assert property (@(posedge clk) disable iff (rst)
        !psc_q[0]); // R6
    AST_IDLE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (ss_n && !tx_empty) |=> !ss_n); // R3
    AST_QUEUE_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_full) |=> stat.busy); // R9

endmodule

// File: tb/ssp_host_port_tb.sv
module ssp_host_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        sclk, ss_n, mosi, miso;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int frames = 0;
    int prev_rise = 0;
    int period = 0;
    logic [15:0] mon_bits = 16'd0;

    always #10 clk = ~clk;

    assign miso = mosi;

    ssp_host_port u_dut (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso)
    );

    always @(negedge clk) cyc++;
    always @(negedge ss_n) begin
        frames++;
        mon_bits = 16'd0;
    end
    always @(posedge sclk) begin
        period    = cyc - prev_rise;
        prev_rise = cyc;
        mon_bits  = {mon_bits[14:0], mosi};
    end

    function automatic int blen(input logic [3:0] code);
        return (code < 4'd3) ? 4 : int'(code) + 1;
    endfunction

    function automatic logic [15:0] lowmask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [15:0] stat_word(input bit te, input bit tnf,
                                              input bit rne, input bit rf,
                                              input bit bsy);
        return {11'b0, bsy, rf, rne, tnf, te};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        reg_rd    = 1'b0;
    endtask

    task automatic idle_bus();
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        s = 16'h0010;
        while (s[4]) begin
            rd(2'd2, s);
        end
        idle_bus();
        idle_bus();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0x0000 expected=0x0001");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] words [10];
        int f0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1, R8: reset state
        rd(2'd2, v); check(v == 16'h0003, "R1 status", v, 16'h0003);
        rd(2'd3, v); check(v == 16'h0000, "R1 prescale", v, 16'h0000);
        check(ss_n == 1'b1 && sclk == 1'b0, "R1 pins", {14'b0, ss_n, sclk}, 16'h0002);

        // R6: prescale low bit forced to zero
        wr(2'd3, 16'h000B); rd(2'd3, v); check(v == 16'h000A, "R6 psc even", v, 16'h000A);
        wr(2'd3, 16'h0007); rd(2'd3, v); check(v == 16'h0006, "R6 psc even", v, 16'h0006);
        // R2: control readback
        wr(2'd0, 16'h0127); rd(2'd0, v); check(v == 16'h0127, "R2 ctrl", v, 16'h0127);

        // R11: empty read
        rd(2'd1, v); check(v == 16'h0000, "R11 empty read", v, 16'h0000);
        rd(2'd2, v); check(v == 16'h0003, "R11 status kept", v, 16'h0003);

        // R3, R4: immediate start, MSB first (prescale 2, divider 0, 8 bits)
        wr(2'd3, 16'h0002);
        wr(2'd0, 16'h0007);
        wr(2'd1, 16'hC3A5);
        idle_bus();
        @(negedge clk);
        check(ss_n == 1'b0, "R3 start", {15'b0, ss_n}, 16'h0000);
        rd(2'd2, v); check(v[4] == 1'b1, "R9 busy in frame", v, 16'h0010);
        wait_idle();
        check(mon_bits[7:0] == 8'hA5, "R4 msb first", mon_bits, 16'h00A5);
        rd(2'd1, v); check(v == 16'h00A5, "R7 rx low bits", v, 16'h00A5);

        // R6: bit period = 4 * (2+1)
        wr(2'd3, 16'h0004);
        wr(2'd0, 16'h002F);
        wr(2'd1, 16'h1234);
        idle_bus();
        wait_idle();
        check(period == 12, "R6 bit period", 16'(period), 16'd12);
        rd(2'd1, v); check(v == 16'h1234, "R4 16-bit loop", v, 16'h1234);

        // R5: short codes clamp to 4 bits
        wr(2'd3, 16'h0002);
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'hFFF6);
        idle_bus();
        wait_idle();
        rd(2'd1, v); check(v == 16'h0006, "R5 clamp len", v, 16'h0006);
        check(mon_bits[3:0] == 4'h6, "R5 four bits sent", mon_bits, 16'h0006);

        // R10, R12, R13: overflow both queues at slow rate
        wr(2'd3, 16'h00FE);
        wr(2'd0, 16'h0003);
        f0 = frames;
        for (int i = 0; i < 10; i++) begin
            words[i] = 16'((i + 1) * 16'h0111);
            wr(2'd1, words[i]);
        end
        idle_bus();
        rd(2'd2, v); check(v == stat_word(0, 0, 0, 0, 1), "R10 tx full", v, stat_word(0, 0, 0, 0, 1));
        wait_idle();
        check(frames - f0 == 9, "R10 write ignored", 16'(frames - f0), 16'd9);
        rd(2'd2, v); check(v == stat_word(1, 1, 1, 1, 0), "R12 rx full", v, stat_word(1, 1, 1, 1, 0));
        for (int i = 0; i < 8; i++) begin
            rd(2'd1, v);
            check(v == (words[i] & 16'h000F), "R12 R13 order", v, words[i] & 16'h000F);
        end
        rd(2'd1, v); check(v == 16'h0000, "R11 drained", v, 16'h0000);
        rd(2'd2, v); check(v == 16'h0003, "R8 idle status", v, 16'h0003);
        idle_bus();

        // random frames: R4 R5 R6 R7 R13
        for (int it = 0; it < 40; it++) begin
            logic [3:0]  code;
            int          n, len;
            logic [15:0] ws [4];
            code = 4'($urandom % 16);
            n    = 1 + int'($urandom % 4);
            len  = blen(code);
            wr(2'd3, 16'(2 * (1 + ($urandom % 4))));
            wr(2'd0, {4'b0, 8'($urandom % 3), code});
            for (int k = 0; k < n; k++) begin
                ws[k] = 16'($urandom);
                wr(2'd1, ws[k]);
            end
            idle_bus();
            wait_idle();
            for (int k = 0; k < n; k++) begin
                rd(2'd1, v);
                check(v == (ws[k] & lowmask(len)), "R7 R13 random", v, ws[k] & lowmask(len));
            end
            idle_bus();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule